// File: doc/BRIEF.md
# Masked Vector Compress/Expand Unit

This unit moves elements between a sparse layout and a dense layout in a 512-bit vector. A selection mask decides which elements take part. In compress mode the selected source elements are packed toward element 0. In expand mode the lowest source elements are handed out, in order, to the selected positions.

The element size can be 32 bits (16 elements) or 64 bits (8 elements). Any destination position the operation does not write is handled in one of two ways, chosen per operation: it is cleared, or it takes its value from a prior-destination vector. Alongside the result the unit returns the number of selected elements.

A request is presented with a one-cycle start strobe. The result is registered and appears with a valid pulse on the following cycle. Requests may be issued back to back, one per cycle.

Top module: `vec_pack_unit`

## Requirements
- R1: In compress mode (`mode_expand`=0), the selected source elements appear in output slots 0, 1, 2, … with no gaps. The lowest-indexed selected element goes to slot 0, and relative order is preserved.
- R2: In expand mode (`mode_expand`=1), the source elements 0, 1, 2, … are written, in that order, to the destination positions whose mask bits are set, starting from the lowest set bit.
- R3: Element size is chosen by `elem64`. With `elem64`=0 the elements are 32-bit lane i = bits [32i+31:32i], and all 16 mask bits are used. With `elem64`=1 the elements are 64-bit element i = bits [64i+63:64i], only `sel_mask[7:0]` is used, and `sel_mask[15:8]` has no effect.
- R4: With `zero_fill`=1, every destination element that is not written is 0.
- R5: With `zero_fill`=0, every destination element that is not written equals the same element of `old_vec`.
- R6: In compress mode, the unwritten elements are exactly the output slots at or above the selected-element count.
- R7: An all-zero effective mask writes no element. The output is then all zero (zeroing) or equal to `old_vec` (merge), and the count is 0.
- R8: An all-ones effective mask copies `src_vec` unchanged in both modes.
- R9: `out_count` equals the number of set bits in the effective mask (0..16).
- R10: `out_valid` is high in the cycle after each cycle in which `start` is high, and low otherwise.
- R11: `out_vec` and `out_count` update only on a start. Otherwise they hold, whatever the inputs do.
- R12: After reset, `out_valid` is 0, `out_vec` is 0 and `out_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, one cycle per operation |
| mode_expand | input | 1 | 0 = compress, 1 = expand |
| elem64 | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| zero_fill | input | 1 | 1 = clear unwritten elements, 0 = merge from old_vec |
| sel_mask | input | 16 | Element selection mask |
| src_vec | input | 512 | Source vector |
| old_vec | input | 512 | Prior destination vector for merging |
| out_valid | output | 1 | Result valid, one cycle after start |
| out_vec | output | 512 | Registered result vector |
| out_count | output | 5 | Number of selected elements |

## Verification
Sparse alternating masks (0xA5A5, 0x0F0F) in both modes show whether the routing follows the running set-bit count rather than the element index. Running each of them under both fill policies separates cleared positions from merged positions. Masks with junk in the upper byte at 64-bit size show whether those bits leak into the element selection. The all-zero and all-ones masks pin down the write-nothing and identity cases. A run of back-to-back random requests, followed by idle cycles with changing inputs, separates correct pipelining from stale or leaking state.

// File: rtl/vec_pack_unit.sv
module vec_pack_unit #(
  parameter int VEC_W = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_expand,
  input  logic             elem64,
  input  logic             zero_fill,
  input  logic [15:0]      sel_mask,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] old_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec,
  output logic [4:0]       out_count
);
  localparam int LN    = VEC_W / 32;
  localparam int EN    = VEC_W / 64;
  localparam int CNT_W = $clog2(LN) + 1;

  logic [LN-1:0]          em;
  logic [LN-1:0][31:0]    s32, o32, r32, r64l, nxt;
  logic [EN-1:0][63:0]    s64, r64;
  logic [LN-1:0]          w32;
  logic [EN-1:0]          w64;
  logic [CNT_W-1:0]       k32, k64, cnt;

  assign em  = elem64 ? {{(LN-EN){1'b0}}, sel_mask[EN-1:0]} : sel_mask[LN-1:0];
  assign cnt = CNT_W'($countones(em));
  assign s32 = src_vec;
  assign s64 = src_vec;
  assign o32 = old_vec;
  assign r64l = r64;

  always_comb begin
    r32 = '0; w32 = '0; k32 = '0;
    for (int i = 0; i < LN; i++) begin
      if (em[i]) begin
        if (mode_expand) begin
          r32[i] = s32[k32[CNT_W-2:0]];
          w32[i] = 1'b1;
        end else begin
          r32[k32[CNT_W-2:0]] = s32[i];
          w32[k32[CNT_W-2:0]] = 1'b1;
        end
        k32 = k32 + 1'b1;
      end
    end
  end

  always_comb begin
    r64 = '0; w64 = '0; k64 = '0;
    for (int i = 0; i < EN; i++) begin
      if (em[i]) begin
        if (mode_expand) begin
          r64[i] = s64[k64[CNT_W-3:0]];
          w64[i] = 1'b1;
        end else begin
          r64[k64[CNT_W-3:0]] = s64[i];
          w64[k64[CNT_W-3:0]] = 1'b1;
        end
        k64 = k64 + 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LN; i++) begin
      if (elem64 ? w64[i/2] : w32[i])
        nxt[i] = elem64 ? r64l[i] : r32[i];
      else
        nxt[i] = zero_fill ? 32'h0 : o32[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_count <= '0;
    end else begin
      out_valid <= start;
      if (start) begin
        out_vec   <= nxt;
        out_count <= 5'(cnt);
      end
    end
  end

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);
  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !out_valid);
  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(out_vec) && $stable(out_count)));
  // R3
  wide_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && elem64) |=> (out_count <= 5'd8));
  // R7
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && zero_fill && em == '0) |=> (out_vec == '0 && out_count == 5'd0));
  // R7
  empty_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !zero_fill && em == '0) |=> (out_vec == $past(old_vec)));
endmodule

// File: tb/vec_pack_unit_tb.sv
module vec_pack_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode_expand = 1'b0;
  logic         elem64 = 1'b0;
  logic         zero_fill = 1'b0;
  logic [15:0]  sel_mask = '0;
  logic [511:0] src_vec = '0;
  logic [511:0] old_vec = '0;
  logic         out_valid;
  logic [511:0] out_vec;
  logic [4:0]   out_count;

  int checks = 0;
  int errors = 0;
  logic [511:0] q_vec[$];
  logic [4:0]   q_cnt[$];
  string        q_tag[$];
  logic [511:0] last_vec = '0;
  logic [4:0]   last_cnt = '0;

  always #5 clk = ~clk;

  vec_pack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_expand(mode_expand),
    .elem64(elem64), .zero_fill(zero_fill), .sel_mask(sel_mask),
    .src_vec(src_vec), .old_vec(old_vec), .out_valid(out_valid),
    .out_vec(out_vec), .out_count(out_count)
  );

  function automatic void model(input logic ex, input logic e64, input logic [15:0] m,
      input logic [511:0] s, input logic [511:0] o, input logic zf,
      output logic [511:0] v, output logic [4:0] c);
    int n, lpe, nsel, src_i;
    bit done [16];
    n = e64 ? 8 : 16;
    lpe = e64 ? 2 : 1;
    nsel = 0;
    for (int i = 0; i < n; i++) if (m[i]) nsel++;
    c = 5'(nsel);
    for (int i = 0; i < 16; i++) done[i] = 0;
    for (int d = 0; d < n; d++) begin
      src_i = -1;
      if (ex) begin
        if (m[d]) begin
          src_i = 0;
          for (int b = 0; b < d; b++) if (m[b]) src_i++;
        end
      end else if (d < nsel) begin
        int seen = 0;
        for (int b = 0; b < n; b++)
          if (m[b]) begin
            if (seen == d) src_i = b;
            seen++;
          end
      end
      for (int l = 0; l < lpe; l++) begin
        int dl = d * lpe + l;
        if (src_i >= 0) v[dl*32 +: 32] = s[(src_i*lpe + l)*32 +: 32];
        else            v[dl*32 +: 32] = zf ? 32'h0 : o[dl*32 +: 32];
        done[dl] = 1;
      end
    end
  endfunction

  task automatic issue(input logic ex, input logic e64, input logic [15:0] m,
      input logic [511:0] s, input logic [511:0] o, input logic zf, input string tag);
    logic [511:0] ev;
    logic [4:0]   ec;
    model(ex, e64, m, s, o, zf, ev, ec);
    q_vec.push_back(ev);
    q_cnt.push_back(ec);
    q_tag.push_back(tag);
    mode_expand = ex; elem64 = e64; sel_mask = m;
    src_vec = s; old_vec = o; zero_fill = zf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [511:0] rnd_vec();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q_vec.size() == 0) begin
        errors++;
        $display("FAIL R10: valid with no request, actual valid=1 expected 0");
      end else begin
        logic [511:0] ev;
        logic [4:0]   ec;
        string        t;
        ev = q_vec.pop_front(); ec = q_cnt.pop_front(); t = q_tag.pop_front();
        if (out_vec !== ev || out_count !== ec) begin
          errors++;
          $display("FAIL %s (R9 count): actual cnt=%0d vec=%h expected cnt=%0d vec=%h",
                   t, out_count, out_vec, ec, ev);
        end
        last_vec = ev; last_cnt = ec;
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] sv, ov, ident;
    for (int i = 0; i < 16; i++) ident[i*32 +: 32] = 32'hA000_0000 + i;
    ov = {16{32'h5555_5555}};
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_vec !== '0 || out_count !== 5'd0) begin
      errors++;
      $display("FAIL R12: actual valid=%b cnt=%0d expected 0/0", out_valid, out_count);
    end
    rst_n = 1'b1;
    @(negedge clk);

    issue(0, 0, 16'hA5A5, ident, ov, 0, "R1 R6 R5 compress32 merge");
    issue(0, 0, 16'hA5A5, ident, ov, 1, "R1 R4 compress32 zero");
    issue(1, 0, 16'h0F0F, ident, ov, 1, "R2 R4 expand32 zero");
    issue(1, 0, 16'h0F0F, ident, ov, 0, "R2 R5 expand32 merge");
    issue(0, 1, 16'hFF81, ident, ov, 1, "R3 compress64 upper ignored");
    issue(1, 1, 16'hCA35, ident, ov, 0, "R3 expand64 upper ignored");
    issue(0, 0, 16'h0000, ident, ov, 0, "R7 empty merge");
    issue(1, 0, 16'h0000, ident, ov, 1, "R7 empty zero");
    issue(0, 1, 16'hFF00, ident, ov, 0, "R7 R3 empty64 merge");
    issue(0, 0, 16'hFFFF, ident, ov, 1, "R8 identity compress32");
    issue(1, 0, 16'hFFFF, ident, ov, 1, "R8 identity expand32");
    issue(0, 1, 16'h00FF, ident, ov, 0, "R8 identity compress64");
    issue(1, 1, 16'h00FF, ident, ov, 1, "R8 identity expand64");
    issue(0, 0, 16'h8000, ident, ov, 0, "R1 R6 top only");
    issue(1, 0, 16'h8000, ident, ov, 0, "R2 top only");
    repeat (2) @(negedge clk);

    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: actual valid=%b expected 0 when idle", out_valid);
    end

    for (int t = 0; t < 30; t++) begin
      sv = rnd_vec(); ov = rnd_vec();
      issue(1'($urandom), 1'($urandom), 16'($urandom), sv, ov, 1'($urandom), "R1 R2 R9 R10 random");
    end
    @(negedge clk);

    for (int t = 0; t < 4; t++) begin
      sel_mask = 16'($urandom); src_vec = rnd_vec(); old_vec = rnd_vec();
      mode_expand = ~mode_expand; zero_fill = ~zero_fill;
      @(negedge clk);
      checks++;
      if (out_vec !== last_vec || out_count !== last_cnt || out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R11: actual cnt=%0d vec=%h expected cnt=%0d vec=%h",
                 out_count, out_vec, last_cnt, last_vec);
      end
    end

    checks++;
    if (q_vec.size() != 0) begin
      errors++;
      $display("FAIL R10: actual %0d results missing expected 0", q_vec.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule